// File: doc/BRIEF.md
# Bus Takeover Arbitration Controller

An add-in processor card can replace the host board's processor as bus master for good. Asserting halt on the host processor does not take it off the bus, because halt has no effect on arbitration. This controller therefore wins the bus through the host's 68000-style arbitration handshake. It asserts bus request and waits for its dedicated grant. Once the shared grant-acknowledge line is free, it drives that line and holds it for as long as it owns the bus.

When another master, such as a DMA engine, requests the bus, the controller stops driving grant-acknowledge so that master can take over. While the bus is yielded, it halts both processors. When the request goes away, it arbitrates again and reclaims the bus. The add-in processor runs only while the card owns the bus. All arbitration inputs from the host are asynchronous and pass through two-flop synchronizers. The enable input is synchronous to the clock.

Top module: `bus_takeover_arb`

## Requirements
- R1: After reset, and while idle, every output is inactive: `host_halt_n`=1, `local_halt_n`=1, `br_out_n`=1, `bgack_oe`=0, `owns_bus`=0.
- R2: While enabled and not idle, `host_halt_n` is held low (0).
- R3: One clock after enable rises, `br_out_n` goes low. `bgack_oe` is asserted only on the clock after the synchronized grant is low and the synchronized `bgack_in_n` is high. While `bgack_in_n` stays low, `bgack_oe` stays 0 and `br_out_n` stays low.
- R4: `owns_bus` equals 1 exactly while the controller drives grant-acknowledge. It stays 1 until another master requests the bus or enable falls.
- R5: `br_out_n` is 1 whenever `bgack_oe` is 1. It is released on the same clock that grant-acknowledge is taken.
- R6: If the synchronized `dma_req_n` is low while the bus is owned, then on the next clock `bgack_oe` is 0, `host_halt_n` is 0 and `local_halt_n` is 0.
- R7: After the synchronized `dma_req_n` returns high, `br_out_n` goes low again on the next clock. The bus is reclaimed under the same grant and acknowledge conditions as in R3.
- R8: `local_halt_n` is 1 only while the bus is owned or while idle. In every other state it is 0.
- R9: A change on `bus_grant_n`, `bgack_in_n` or `dma_req_n` reaches the outputs on the third rising edge after it is applied, and not before.
- R10: On the clock after enable is low, the controller is idle and every output is inactive, whatever state it was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Card enable, synchronous |
| dma_req_n | input | 1 | Host bus request from other masters, active low, asynchronous |
| bus_grant_n | input | 1 | Dedicated grant to this card, active low, asynchronous |
| bgack_in_n | input | 1 | Sampled shared grant-acknowledge, active low, asynchronous |
| host_halt_n | output | 1 | Halt to the host processor, active low |
| local_halt_n | output | 1 | Halt to the add-in processor, active low |
| br_out_n | output | 1 | Bus request to the host arbiter, active low |
| bgack_oe | output | 1 | Drive enable for the shared grant-acknowledge line (drives it low) |
| owns_bus | output | 1 | Add-in processor currently owns the bus |

## Verification
Some properties are checked on every cycle. The request is never held together with the acknowledge drive. Grant-acknowledge is taken only after the synchronized grant was present and the line was seen free. A yield halts both processors. Disable clears everything. The add-in processor never runs outside ownership. Only the bench scenarios can show the three-edge synchronizer latency, the full take-yield-reclaim sequence against a DMA master that keeps holding acknowledge, and agreement with a cycle model under random arbitration traffic.

// File: rtl/bus_takeover_arb.sv
module bus_takeover_arb #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic dma_req_n,
  input  logic bus_grant_n,
  input  logic bgack_in_n,
  output logic host_halt_n,
  output logic local_halt_n,
  output logic br_out_n,
  output logic bgack_oe,
  output logic owns_bus
);

  typedef enum logic [2:0] {IDLE, REQUEST, WAIT_GRANT, OWN, YIELD, RECLAIM} state_t;

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] req_q, gnt_q, ack_q;
  logic req_s, gnt_s, ack_s;
  state_t st, st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_q <= '1;
      gnt_q <= '1;
      ack_q <= '1;
    end else begin
      req_q <= {req_q[TOP-1:0], dma_req_n};
      gnt_q <= {gnt_q[TOP-1:0], bus_grant_n};
      ack_q <= {ack_q[TOP-1:0], bgack_in_n};
    end

  assign req_s = req_q[TOP];
  assign gnt_s = gnt_q[TOP];
  assign ack_s = ack_q[TOP];

  always_comb begin
    st_nx = st;
    if (!enable) st_nx = IDLE;
    else
      case (st)
        IDLE:       st_nx = REQUEST;
        REQUEST,
        RECLAIM:    if (!gnt_s) st_nx = ack_s ? OWN : WAIT_GRANT;
        WAIT_GRANT: if (gnt_s) st_nx = REQUEST;
                    else if (ack_s) st_nx = OWN;
        OWN:        if (!req_s) st_nx = YIELD;
        YIELD:      if (req_s) st_nx = RECLAIM;
        default:    st_nx = IDLE;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= IDLE;
    else        st <= st_nx;

  assign host_halt_n  = (st == IDLE);
  assign local_halt_n = (st == IDLE) || (st == OWN);
  assign br_out_n     = !(st == REQUEST || st == WAIT_GRANT || st == RECLAIM);
  assign bgack_oe     = (st == OWN);
  assign owns_bus     = (st == OWN);

endmodule

module bus_takeover_arb_sva (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic req_s,
  input logic gnt_s,
  input logic ack_s,
  input logic host_halt_n,
  input logic local_halt_n,
  input logic br_out_n,
  input logic bgack_oe,
  input logic owns_bus
);

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bgack_oe |-> br_out_n);

  assert_ack_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bgack_oe) |-> ($past(!gnt_s) && $past(ack_s) && $past(enable)));

  assert_host_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bgack_oe || !br_out_n || !local_halt_n) |-> !host_halt_n);

  assert_local_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    local_halt_n |-> (owns_bus || host_halt_n));

  assert_yield_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (owns_bus && !req_s && enable) |=> (!bgack_oe && !host_halt_n && !local_halt_n));

  assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (host_halt_n && local_halt_n && br_out_n && !bgack_oe && !owns_bus));

endmodule

bind bus_takeover_arb bus_takeover_arb_sva u_sva (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .req_s(req_s), .gnt_s(gnt_s), .ack_s(ack_s),
  .host_halt_n(host_halt_n), .local_halt_n(local_halt_n),
  .br_out_n(br_out_n), .bgack_oe(bgack_oe), .owns_bus(owns_bus)
);

// File: tb/tb_bus_takeover_arb.sv
module tb_bus_takeover_arb;
  logic clk = 0, rst_n = 0;
  logic enable = 0, dma_req_n = 1, bus_grant_n = 1, bgack_in_n = 1;
  logic host_halt_n, local_halt_n, br_out_n, bgack_oe, owns_bus;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_takeover_arb dut (.*);

  // bench cycle model: 0 idle,1 req,2 waitgrant,3 own,4 yield,5 reclaim
  int m_st;
  logic m_r1, m_r2, m_g1, m_g2, m_a1, m_a2;

  function automatic int nxt(int s, logic en, logic r, logic g, logic a);
    if (!en) return 0;
    case (s)
      0: return 1;
      1, 5: return g ? s : (a ? 3 : 2);
      2: return g ? 1 : (a ? 3 : 2);
      3: return r ? 3 : 4;
      4: return r ? 5 : 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [4:0] exp_out(int s);
    // {host_halt_n, local_halt_n, br_out_n, bgack_oe, owns_bus}
    case (s)
      0: return 5'b11100;
      1, 2, 5: return 5'b00000;
      3: return 5'b01111;
      default: return 5'b00100;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_st <= 0;
      {m_r1, m_r2, m_g1, m_g2, m_a1, m_a2} <= '1;
    end else begin
      m_r1 <= dma_req_n;   m_r2 <= m_r1;
      m_g1 <= bus_grant_n; m_g2 <= m_g1;
      m_a1 <= bgack_in_n;  m_a2 <= m_a1;
      m_st <= nxt(m_st, enable, m_r2, m_g2, m_a2);
    end

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req, logic [4:0] e);
    chk({req, " host_halt_n"},  host_halt_n,  e[4]);
    chk({req, " local_halt_n"}, local_halt_n, e[3]);
    chk({req, " br_out_n"},     br_out_n,     e[2]);
    chk({req, " bgack_oe"},     bgack_oe,     e[1]);
    chk({req, " owns_bus"},     owns_bus,     e[0]);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    rst_n = 1;
    tick(1);
    chk_all("R1 reset", 5'b11100);

    enable = 1;
    tick(1);
    chk("R2 host halted", host_halt_n, 0);
    chk("R3 request out", br_out_n, 0);
    chk("R8 local halted", local_halt_n, 0);

    bus_grant_n = 0;
    tick(2);
    chk("R9 no early ack", bgack_oe, 0);
    tick(1);
    chk("R9 ack on third edge", bgack_oe, 1);
    chk("R5 request dropped", br_out_n, 1);
    chk("R4 owns", owns_bus, 1);
    chk("R8 local runs", local_halt_n, 1);
    tick(4);
    chk("R4 still owns", owns_bus, 1);

    dma_req_n = 0;
    tick(3);
    chk_all("R6 yield", 5'b00100);
    bus_grant_n = 1; bgack_in_n = 0;
    tick(4);
    chk("R6 still yielded", bgack_oe, 0);

    dma_req_n = 1; bus_grant_n = 0;
    tick(3);
    chk("R7 request again", br_out_n, 0);
    tick(5);
    chk("R3 ack busy no drive", bgack_oe, 0);
    chk("R3 ack busy request held", br_out_n, 0);
    bgack_in_n = 1;
    tick(3);
    chk("R7 reclaimed", bgack_oe, 1);
    chk("R7 reclaimed req off", br_out_n, 1);

    enable = 0;
    tick(1);
    chk_all("R10 disable", 5'b11100);

    for (int i = 0; i < 4000; i++) begin
      chk_all("R2/R3/R4/R5/R6/R7/R8 random", exp_out(m_st));
      if ($urandom % 60 == 0) enable = ~enable;
      if ($urandom % 9 == 0) dma_req_n = ~dma_req_n;
      if ($urandom % 7 == 0) bus_grant_n = ~bus_grant_n;
      if ($urandom % 7 == 0) bgack_in_n = ~bgack_in_n;
      tick(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule